// File: doc/BRIEF.md
# DMA Memory-Side Burst Scheduler

This block decides when and how the memory side of a DMA stream empties a 16-byte staging FIFO. A stream is set up through a thin set of inputs: the drain threshold (a quarter, half, three quarters or all of the FIFO), the memory item width, the memory burst length, the peripheral item width and burst length, and the number of memory items to move. On `start`, the block checks the setup. An illegal setup raises `cfg_err` and the stream does not run.

Once a legal stream runs, the block watches the FIFO fill level given on `fifo_level`. Each time enough data is present, it issues a group of equal bursts on a request/grant memory port. The group always drains exactly one threshold's worth of bytes. When less than one threshold remains in the whole transfer, the block finishes with whole bursts for as long as a full burst still fits. It then sends the last items one by one. Each granted burst produces one beat per cycle. The byte address steps by the item width on every beat, and a one-cycle `done` marks the last item.

Top module: `dma_burst_sched`

## Requirements
- R1: After reset, `req`, `beat`, `done` and `cfg_err` are low.
- R2: Codes are fixed as follows. `thr_sel` 0/1/2/3 selects 4/8/12/16 bytes. Size codes 0/1/2 mean 1/2/4 bytes and code 3 is illegal. Burst codes 0/1/2/3 mean single/4/8/16 beats. On `start`, the setup is illegal if the memory item width times the memory beat count exceeds 16 bytes, or if the threshold bytes are not a whole multiple of that product. An illegal setup sets `cfg_err`, and no `req` or `beat` follows. A later legal `start` clears `cfg_err`.
- R3: The setup is also illegal if the peripheral item width times the peripheral beat count exceeds 16 bytes. It is illegal as well if that product equals 16 bytes and `thr_sel` is 2.
- R4: While the remaining bytes are at least the threshold, the block waits until `fifo_level` is at least the threshold. It then issues threshold/(beats×width) bursts of the configured beat count, back to back. No beat ever drains data the FIFO does not hold.
- R5: With the single burst code, each threshold event issues threshold/width requests of one beat each.
- R6: When fewer than threshold bytes remain, the block sends full bursts while at least one full burst of items remains. Every item left after that goes out as a one-beat request.
- R7: `req` stays high with a stable `req_beats` until `gnt` is sampled high. The beats then follow on consecutive cycles, starting the cycle after the grant. Exactly `req_beats` beats are issued for each grant.
- R8: `mem_addr` is cleared to zero on a legal start. It rises by the item width in bytes on every beat.
- R9: `done` pulses for one cycle after the beat that moves the last item, or right after `start` when `item_count` is zero. The total number of beats equals `item_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a stream when the block is idle |
| thr_sel | input | 2 | Drain threshold code |
| mem_size | input | 2 | Memory item width code |
| mem_burst | input | 2 | Memory burst length code |
| per_size | input | 2 | Peripheral item width code |
| per_burst | input | 2 | Peripheral burst length code |
| item_count | input | CNT_W | Memory items to move |
| fifo_level | input | $clog2(FIFO_BYTES+1) | Bytes currently held in the FIFO |
| req | output | 1 | Memory request |
| req_beats | output | 5 | Beats in the requested burst |
| gnt | input | 1 | Memory grant |
| beat | output | 1 | One item moves this cycle |
| mem_addr | output | ADDR_W | Byte address of the current beat |
| done | output | 1 | One-cycle end-of-transfer pulse |
| cfg_err | output | 1 | Last start carried an illegal setup |

## Verification
The bench builds the block with its default parameters: a 16-byte FIFO, a 16-bit item counter and a 32-bit address. These values cover every threshold, width and burst code, including the 16-beat byte bursts that fill the whole FIFO and the word bursts that exceed it. A modelled FIFO fills one byte per cycle and drains on each beat, so any burst issued ahead of the data shows up as a negative level. Grant latency varies from case to case. Item counts are chosen to leave tails shorter than a threshold, shorter than a burst, or empty.

// File: rtl/dma_burst_sched.sv
module dma_burst_sched #(
  parameter int FIFO_BYTES = 16,
  parameter int CNT_W      = 16,
  parameter int ADDR_W     = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            start,
  input  logic [1:0]                      thr_sel,
  input  logic [1:0]                      mem_size,
  input  logic [1:0]                      mem_burst,
  input  logic [1:0]                      per_size,
  input  logic [1:0]                      per_burst,
  input  logic [CNT_W-1:0]                item_count,
  input  logic [$clog2(FIFO_BYTES+1)-1:0] fifo_level,
  output logic                            req,
  output logic [4:0]                      req_beats,
  input  logic                            gnt,
  output logic                            beat,
  output logic [ADDR_W-1:0]               mem_addr,
  output logic                            done,
  output logic                            cfg_err
);
  localparam int LVL_W = $clog2(FIFO_BYTES+1);
  localparam int BW    = 8;
  localparam int RB_W  = CNT_W + 2;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_REQ, S_XFER} state_t;

  function automatic logic [BW-1:0] beats_of(input logic [1:0] c);
    case (c)
      2'd0:    return BW'(1);
      2'd1:    return BW'(4);
      2'd2:    return BW'(8);
      default: return BW'(16);
    endcase
  endfunction

  function automatic logic [2:0] lg_of(input logic [1:0] c);
    case (c)
      2'd0:    return 3'd0;
      2'd1:    return 3'd2;
      2'd2:    return 3'd3;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [BW-1:0] thr_bytes(input logic [1:0] t);
    return BW'((32'(t) + 1) * (FIFO_BYTES / 4));
  endfunction

  state_t          state;
  logic [1:0]      l_thr, l_ms, l_mb;
  logic [CNT_W-1:0] rem;
  logic [BW-1:0]   groups_left;
  logic [4:0]      beat_cnt;

  // setup check on live inputs
  logic [BW-1:0] fb, tb_in, m_bb, p_bb;
  logic          cfg_bad;
  assign fb      = BW'(FIFO_BYTES);
  assign tb_in   = thr_bytes(thr_sel);
  assign m_bb    = beats_of(mem_burst) << mem_size;
  assign p_bb    = beats_of(per_burst) << per_size;
  assign cfg_bad = (mem_size == 2'd3) || (per_size == 2'd3) || (m_bb > fb) ||
                   ((tb_in & (m_bb - BW'(1))) != '0) || (p_bb > fb) ||
                   ((p_bb == fb) && (thr_sel == 2'd2));

  // run-time decisions on latched setup
  logic [BW-1:0]   tb_l, sz_l, bt_l, bb_l, need, nb, len;
  logic [RB_W-1:0] rem_b;
  logic            ev, tail_burst, lvl_ok;
  assign tb_l       = thr_bytes(l_thr);
  assign sz_l       = BW'(1) << l_ms;
  assign bt_l       = beats_of(l_mb);
  assign bb_l       = bt_l << l_ms;
  assign rem_b      = {2'b00, rem} << l_ms;
  assign ev         = rem_b >= RB_W'(tb_l);
  assign tail_burst = (l_mb != 2'd0) && (rem >= CNT_W'(bt_l));
  assign need       = ev ? tb_l : (tail_burst ? bb_l : sz_l);
  assign nb         = !ev ? BW'(1) :
                      (l_mb == 2'd0) ? (tb_l >> l_ms) : (tb_l >> (lg_of(l_mb) + {1'b0, l_ms}));
  assign len        = (l_mb != 2'd0 && (ev || tail_burst)) ? bt_l : BW'(1);
  assign lvl_ok     = {{(BW-LVL_W){1'b0}}, fifo_level} >= need;

  assign req  = (state == S_REQ);
  assign beat = (state == S_XFER);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      l_thr       <= '0;
      l_ms        <= '0;
      l_mb        <= '0;
      rem         <= '0;
      groups_left <= '0;
      beat_cnt    <= '0;
      req_beats   <= '0;
      mem_addr    <= '0;
      done        <= 1'b0;
      cfg_err     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          cfg_err <= cfg_bad;
          if (!cfg_bad) begin
            l_thr    <= thr_sel;
            l_ms     <= mem_size;
            l_mb     <= mem_burst;
            rem      <= item_count;
            mem_addr <= '0;
            if (item_count == '0) done  <= 1'b1;
            else                  state <= S_WAIT;
          end
        end
        S_WAIT: if (lvl_ok) begin
          groups_left <= nb;
          req_beats   <= 5'(len);
          state       <= S_REQ;
        end
        S_REQ: if (gnt) begin
          beat_cnt <= req_beats;
          state    <= S_XFER;
        end
        default: begin
          mem_addr <= mem_addr + ADDR_W'(sz_l);
          rem      <= rem - CNT_W'(1);
          beat_cnt <= beat_cnt - 5'd1;
          if (beat_cnt == 5'd1) begin
            if (rem == CNT_W'(1)) begin
              done  <= 1'b1;
              state <= S_IDLE;
            end else if (groups_left > BW'(1)) begin
              groups_left <= groups_left - BW'(1);
              state       <= S_REQ;
            end else begin
              state <= S_WAIT;
            end
          end
        end
      endcase
    end
  end

  assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req && !gnt |=> req && $stable(req_beats));
  assert_beats_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req) |-> beat);
  assert_err_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !req && !beat);
  assert_beat_has_item_R9: assert property (@(posedge clk) disable iff (!rst_n)
    beat |-> rem != '0);
  assert_done_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !req && !beat);
  assert_addr_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    beat |=> mem_addr == $past(mem_addr) + ADDR_W'(sz_l));
endmodule

// File: tb/dma_burst_sched_test.sv
module dma_burst_sched_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  thr_sel = '0, mem_size = '0, mem_burst = '0, per_size = '0, per_burst = '0;
  logic [15:0] item_count = '0;
  logic [4:0]  fifo_level = '0;
  logic        req, beat, done, cfg_err;
  logic [4:0]  req_beats;
  logic        gnt = 1'b0;
  logic [31:0] mem_addr;

  always #10 clk = ~clk;

  dma_burst_sched uut (
    .clk(clk), .rst_n(rst_n), .start(start), .thr_sel(thr_sel), .mem_size(mem_size),
    .mem_burst(mem_burst), .per_size(per_size), .per_burst(per_burst),
    .item_count(item_count), .fifo_level(fifo_level), .req(req), .req_beats(req_beats),
    .gnt(gnt), .beat(beat), .mem_addr(mem_addr), .done(done), .cfg_err(cfg_err)
  );

  int compared = 0, mismatched = 0;
  int exp_q[$];
  int lvl = 0, pushed = 0, total = 0, sz = 1;
  int beats_seen = 0, dones = 0, reqs_seen = 0, gdel = 0, hold = 0;
  bit finished = 0;
  string cur_tag = "";

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor, grant driver and FIFO model
  always @(negedge clk) begin
    bit g;
    g = 0;
    if (req) begin
      if (hold >= gdel) begin g = 1; hold = 0; end
      else hold++;
    end
    gnt <= g;
    if (g) begin
      reqs_seen++;
      if (exp_q.size() == 0) chk(0, {cur_tag, " extra request"}, int'(req_beats), 0);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(int'(req_beats) == e, {cur_tag, " burst length"}, int'(req_beats), e);
      end
    end
    if (beat) begin
      beats_seen++;
      lvl -= sz;
      if (lvl < 0) begin
        chk(0, {cur_tag, " R4 FIFO underflow"}, lvl, 0);
        lvl = 0;
      end
    end
    if (done) dones++;
    if (pushed < total && lvl < 16) begin lvl++; pushed++; end
    fifo_level <= 5'(lvl);
  end

  task automatic run_case(input int thr, input int ms, input int mb, input int ps, input int pb,
                          input int cnt, input int gd, input string tag);
    int tb, bt, rem;
    @(posedge clk);
    cur_tag = tag;
    sz = 1 << ms;
    tb = (thr + 1) * 4;
    bt = (mb == 0) ? 1 : (mb == 1) ? 4 : (mb == 2) ? 8 : 16;
    exp_q.delete();
    rem = cnt;
    while (rem > 0) begin
      if (rem * sz >= tb) begin
        if (mb == 0) begin
          for (int i = 0; i < tb / sz; i++) exp_q.push_back(1);
          rem -= tb / sz;
        end else begin
          for (int i = 0; i < tb / (bt * sz); i++) exp_q.push_back(bt);
          rem -= tb / sz;
        end
      end else if (bt > 1 && rem >= bt) begin
        exp_q.push_back(bt); rem -= bt;
      end else begin
        exp_q.push_back(1); rem -= 1;
      end
    end
    lvl = 0; pushed = 0; beats_seen = 0; dones = 0; reqs_seen = 0; hold = 0; gdel = gd;
    total = cnt * sz;
    @(negedge clk);
    thr_sel = 2'(thr); mem_size = 2'(ms); mem_burst = 2'(mb);
    per_size = 2'(ps); per_burst = 2'(pb); item_count = 16'(cnt);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 6000 && dones == 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(dones == 1, {tag, " R9 done pulses"}, dones, 1);
    chk(beats_seen == cnt, {tag, " R9 beat total"}, beats_seen, cnt);
    chk(exp_q.size() == 0, {tag, " R4/R6 requests left unissued"}, exp_q.size(), 0);
    chk(int'(mem_addr) == cnt * sz, {tag, " R8 final address"}, int'(mem_addr), cnt * sz);
    chk(cfg_err == 1'b0, {tag, " R2 legal setup flagged"}, int'(cfg_err), 0);
  endtask

  task automatic bad_case(input int thr, input int ms, input int mb, input int ps, input int pb,
                          input string tag);
    @(posedge clk);
    cur_tag = tag;
    exp_q.delete();
    total = 0; reqs_seen = 0; beats_seen = 0; dones = 0;
    @(negedge clk);
    thr_sel = 2'(thr); mem_size = 2'(ms); mem_burst = 2'(mb);
    per_size = 2'(ps); per_burst = 2'(pb); item_count = 16'd8;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (12) @(negedge clk);
    chk(cfg_err == 1'b1, {tag, " error flag"}, int'(cfg_err), 1);
    chk(reqs_seen == 0 && beats_seen == 0 && dones == 0, {tag, " stream ran"},
        reqs_seen + beats_seen + dones, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      chk(0, "watchdog expired", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req == 0, "R1 req after reset", int'(req), 0);
    chk(beat == 0, "R1 beat after reset", int'(beat), 0);
    chk(done == 0, "R1 done after reset", int'(done), 0);
    chk(cfg_err == 0, "R1 cfg_err after reset", int'(cfg_err), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_case(0, 0, 1, 0, 0, 10, 0, "R4 byte x4 quarter");
    run_case(3, 0, 1, 0, 1, 37, 2, "R4 byte x4 full");
    run_case(1, 1, 1, 1, 1, 9, 1, "R4 half x4 half");
    run_case(3, 2, 1, 2, 0, 6, 3, "R6 word x4 full");
    run_case(2, 0, 0, 0, 0, 14, 1, "R5 byte single 3/4");
    run_case(3, 0, 3, 0, 3, 20, 0, "R6 byte x16 full");
    run_case(3, 1, 2, 2, 1, 8, 2, "R4 half x8 full");
    run_case(1, 2, 0, 1, 2, 3, 0, "R5 word single half");
    run_case(0, 0, 1, 0, 0, 0, 0, "R9 zero items");

    bad_case(0, 1, 1, 0, 0, "R2 half x4 quarter");
    bad_case(2, 0, 2, 0, 0, "R2 byte x8 3/4");
    bad_case(1, 2, 1, 0, 0, "R2 word x4 half");
    bad_case(3, 2, 2, 0, 0, "R2 word x8 too big");
    bad_case(1, 3, 0, 0, 0, "R2 size code 3");
    bad_case(2, 0, 0, 0, 3, "R3 peripheral 16 bytes at 3/4");
    bad_case(3, 0, 0, 2, 2, "R3 peripheral 32 bytes");

    run_case(3, 0, 0, 0, 3, 5, 1, "R2 legal start clears error");

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule